// File: doc/BRIEF.md
# Trace-Driven Traffic Generator

This block stands in for one computation node during on-chip network studies. It replays a stored list of network accesses, one list per node, and offers each access as a request on a valid/ready port. An access carries a source ID, a destination ID, an operation code, a transfer size and a memory address. Each stored entry also holds a gap: the number of idle cycles to insert before the access is offered.

The gap is counted from the moment the previous request was accepted. It is not an absolute time. When the network applies backpressure, every later access moves out by the length of the stall, and the spacing between accesses stays the same.

A statistical mode ignores the stored gaps. It opens each gap with a pseudo-random test on every idle cycle, which gives geometric inter-arrival times, the discrete form of Poisson arrivals. Entries are written through a load port. A start pulse rewinds the replay to entry 0. Two counters report accepted requests and stalled cycles.

Top module: `trace_traffic_gen`

## Requirements
- R1: After reset, `req_valid`, `done`, `issued_cnt` and `stall_cnt` are all zero, and no request is offered until `start` is pulsed.
- R2: A `start` pulse does all of the following:
  - It rewinds the replay to entry 0.
  - It clears `done` and both counters.
  - It overrides a handshake in the same cycle, and that handshake is not counted.
- R3: In replay mode, entry k waits a stored number of cycles, gap g. After the `start` edge (for entry 0) or the accepting edge of entry k-1, `req_valid` is low for exactly g cycles and then rises. A gap of 0 makes `req_valid` stay high, so requests go back to back.
- R4: While a request is offered, `req_src`, `req_dst`, `req_op` and `req_size` equal the fields of the current entry. Entries are offered in index order. The operation codes are 0 read, 1 write, 2 message and 3 sync.
- R5: `req_addr` equals the stored address for codes 0 and 1. It is zero for codes 2 and 3.
- R6: An offered request stays valid with stable fields until `req_ready` is high. Stall cycles do not change the gap counts of later entries.
- R7: The replay ends on the cycle after entry `cfg_len`-1 is accepted: `done` goes high and `req_valid` goes low. With `cfg_len` = 0, `done` is high on the cycle after `start`.
- R8: In statistical mode the stored gaps are ignored. After each start or acceptance, at least one idle cycle follows. Every idle cycle ends the gap when the free-running 16-bit LFSR value is at most `cfg_thresh`. So a threshold of 0xFFFF gives gaps of exactly one cycle, and a threshold of 0 never issues.
- R9: `issued_cnt` counts accepted requests. `stall_cnt` counts cycles with `req_valid` high and `req_ready` low. Both counters saturate.
- R10: With `ld_en` high, the field inputs are written into entry `ld_idx` at the clock edge, and the next replay uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one trace entry |
| ld_idx | input | 4 | Entry index to write |
| ld_gap | input | 8 | Gap in cycles for that entry |
| ld_src | input | 4 | Source ID for that entry |
| ld_dst | input | 4 | Destination ID for that entry |
| ld_op | input | 2 | Operation code for that entry |
| ld_size | input | 6 | Transfer size for that entry |
| ld_addr | input | 16 | Memory address for that entry |
| cfg_len | input | 5 | Number of entries to replay |
| cfg_stat | input | 1 | 1 selects statistical gaps |
| cfg_thresh | input | 16 | Threshold for the statistical gap test |
| start | input | 1 | Rewind to entry 0 and begin |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high with valid |
| req_src | output | 4 | Request source ID |
| req_dst | output | 4 | Request destination ID |
| req_op | output | 2 | Request operation code |
| req_size | output | 6 | Request transfer size |
| req_addr | output | 16 | Request address, zero for non-memory codes |
| done | output | 1 | Last entry accepted |
| issued_cnt | output | 16 | Accepted request count |
| stall_cnt | output | 16 | Stalled cycle count |

## Verification
Two collisions matter here. A restart can land in the same cycle as a handshake, and a stall can land on the cycle in which the gap of the next entry would otherwise start counting.

The bench provokes the first case by pulsing `start` while a request is offered and `req_ready` is high. It then expects both counters at zero and the first gap of entry 0 restarted from that edge.

It provokes the second case by sweeping three ready patterns over several trace variants, each with gaps from 0 to 7. For every accepted entry, the bench counts the idle cycles measured after the preceding acceptance and compares them with the stored gap. Bursty stalls must shift later requests without changing that count.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
// Shared types for the trace-driven traffic generator.
// Assumes a 2-bit operation code where codes below 2 address memory.
package tg_pkg;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_MSG  = 2'd2,
        OP_SYNC = 2'd3
    } tg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } tg_state_e;

    // True when the operation code carries a meaningful address.
    function automatic logic op_is_mem(input logic [1:0] op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/tg_trace_ram.sv
`timescale 1ns/1ps
// Trace storage: one write port fed by the load interface and one
// asynchronous read port addressed by the issue controller.
// Assumes the contents are loaded before a replay reads them.
module tg_trace_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 40,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one entry per load cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Entry look-up for the controller's next index.
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/tg_gap_lfsr.sv
`timescale 1ns/1ps
// Free-running Galois LFSR plus threshold compare. An asserted fire
// output closes a statistical gap; a per-cycle test with fixed
// probability yields geometric gaps. Assumes a nonzero seed.
module tg_gap_lfsr #(
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] thresh,
    output logic              fire
);

    logic [LFSR_W-1:0] lfsr_q;

    // Advance the register one step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    // Fire when the current value does not exceed the threshold.
    assign fire = (lfsr_q <= thresh);

    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/tg_issue_ctl.sv
`timescale 1ns/1ps
// Replay sequencer. Walks entry indices, counts each gap from the
// accepting edge of the previous request (or from start) and raises
// the request valid. Assumes ent_gap is the gap of entry rd_idx.
module tg_issue_ctl
    import tg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int GAP_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stat_mode,
    input  logic [LEN_W-1:0] len,
    input  logic             fire,
    input  logic [GAP_W-1:0] ent_gap,
    output logic [IDX_W-1:0] rd_idx,
    output logic             capture,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             done,
    output logic             hs
);

    tg_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [GAP_W-1:0] cnt;
    logic [LEN_W-1:0] idx_ext;
    logic             last;
    logic             zero_gap;

    // Derive handshake, end-of-trace and the index to look up next.
    always_comb begin
        idx_ext   = LEN_W'(idx);
        last      = (idx_ext + LEN_W'(1)) == len;
        req_valid = (state == ST_ISSUE);
        done      = (state == ST_DONE);
        hs        = req_valid && req_ready;
        rd_idx    = start ? '0 : idx + IDX_W'(1);
        zero_gap  = !stat_mode && (ent_gap == '0);
        capture   = (start && (len != '0)) || (hs && !last && !start);
    end

    // Sequencer: restart has priority over every other transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else if (start) begin
            idx <= '0;
            cnt <= ent_gap;
            if (len == '0) begin
                state <= ST_DONE;
            end else begin
                state <= zero_gap ? ST_ISSUE : ST_WAIT;
            end
        end else begin
            case (state)
                ST_WAIT: begin
                    if (stat_mode) begin
                        if (fire) state <= ST_ISSUE;
                    end else if (cnt <= GAP_W'(1)) begin
                        state <= ST_ISSUE;
                    end else begin
                        cnt <= cnt - GAP_W'(1);
                    end
                end
                ST_ISSUE: begin
                    if (req_ready) begin
                        if (last) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            cnt   <= ent_gap;
                            state <= zero_gap ? ST_ISSUE : ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !start) |=> req_valid);

    p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !start && !last && !stat_mode && ent_gap == '0) |=> req_valid);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(hs) || $past(start)));

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> !done);

    p_stat_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && stat_mode && fire && !start) |=> req_valid);

endmodule

// File: rtl/tg_stats.sv
`timescale 1ns/1ps
// Saturating counters of accepted requests and stalled cycles.
// Assumes clear is the replay restart pulse.
module tg_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hs,
    input  logic             stall,
    output logic [CNT_W-1:0] issued,
    output logic [CNT_W-1:0] stalls
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            issued <= '0;
            stalls <= '0;
        end else begin
            if (hs && issued != CNT_MAX) issued <= issued + CNT_W'(1);
            if (stall && stalls != CNT_MAX) stalls <= stalls + CNT_W'(1);
        end
    end

    p_issue_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !clear && issued != CNT_MAX) |=> issued == $past(issued) + CNT_W'(1));

    p_stall_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !clear) |=> $stable(stalls));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (issued == '0 && stalls == '0));

endmodule

// File: rtl/trace_traffic_gen.sv
`timescale 1ns/1ps
// Trace-driven traffic generator top. Holds the trace store, the
// sequencer, the statistical gap source and the counters, and
// registers the request fields of the entry being offered.
// Assumes entries are loaded while no replay reads them.
module trace_traffic_gen
    import tg_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int GAP_W  = 8,
    parameter int ID_W   = 4,
    parameter int SIZE_W = 6,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int RND_W  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [GAP_W-1:0]  ld_gap,
    input  logic [ID_W-1:0]   ld_src,
    input  logic [ID_W-1:0]   ld_dst,
    input  logic [1:0]        ld_op,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_stat,
    input  logic [RND_W-1:0]  cfg_thresh,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ID_W-1:0]   req_src,
    output logic [ID_W-1:0]   req_dst,
    output logic [1:0]        req_op,
    output logic [SIZE_W-1:0] req_size,
    output logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic [CNT_W-1:0]  issued_cnt,
    output logic [CNT_W-1:0]  stall_cnt
);

    localparam int OP_W     = 2;
    localparam int OFF_SIZE = ADDR_W;
    localparam int OFF_OP   = OFF_SIZE + SIZE_W;
    localparam int OFF_DST  = OFF_OP + OP_W;
    localparam int OFF_SRC  = OFF_DST + ID_W;
    localparam int OFF_GAP  = OFF_SRC + ID_W;
    localparam int ENT_W    = OFF_GAP + GAP_W;

    logic [ENT_W-1:0]  wr_word;
    logic [ENT_W-1:0]  rd_word;
    logic [IDX_W-1:0]  rd_idx;
    logic              capture;
    logic              hs;
    logic              fire;
    logic [GAP_W-1:0]  ent_gap;
    logic [ID_W-1:0]   ent_src;
    logic [ID_W-1:0]   ent_dst;
    logic [OP_W-1:0]   ent_op;
    logic [SIZE_W-1:0] ent_size;
    logic [ADDR_W-1:0] ent_addr;

    // Pack load fields and split the looked-up entry.
    always_comb begin
        wr_word  = {ld_gap, ld_src, ld_dst, ld_op, ld_size, ld_addr};
        ent_addr = rd_word[ADDR_W-1:0];
        ent_size = rd_word[OFF_SIZE +: SIZE_W];
        ent_op   = rd_word[OFF_OP +: OP_W];
        ent_dst  = rd_word[OFF_DST +: ID_W];
        ent_src  = rd_word[OFF_SRC +: ID_W];
        ent_gap  = rd_word[OFF_GAP +: GAP_W];
    end

    tg_trace_ram #(
        .DEPTH (DEPTH),
        .WIDTH (ENT_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_idx  (ld_idx),
        .wr_data (wr_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_word)
    );

    tg_gap_lfsr #(
        .LFSR_W (RND_W)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .thresh (cfg_thresh),
        .fire   (fire)
    );

    tg_issue_ctl #(
        .DEPTH (DEPTH),
        .GAP_W (GAP_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stat_mode (cfg_stat),
        .len       (cfg_len),
        .fire      (fire),
        .ent_gap   (ent_gap),
        .rd_idx    (rd_idx),
        .capture   (capture),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .done      (done),
        .hs        (hs)
    );

    tg_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .hs     (hs && !start),
        .stall  (req_valid && !req_ready && !start),
        .issued (issued_cnt),
        .stalls (stall_cnt)
    );

    // Latch the next entry's request fields; mask non-memory addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_src  <= '0;
            req_dst  <= '0;
            req_op   <= '0;
            req_size <= '0;
            req_addr <= '0;
        end else if (capture) begin
            req_src  <= ent_src;
            req_dst  <= ent_dst;
            req_op   <= ent_op;
            req_size <= ent_size;
            req_addr <= op_is_mem(ent_op) ? ent_addr : '0;
        end
    end

    p_addr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_is_mem(req_op)) |-> req_addr == '0);

    p_fields_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !start) |=>
            ($stable(req_src) && $stable(req_dst) && $stable(req_op)
             && $stable(req_size) && $stable(req_addr)));

endmodule

// File: tb/trace_traffic_gen_tb.sv
`timescale 1ns/1ps
// Sweeps trace variants, lengths and ready patterns; expected fields
// and gaps are computed from index arithmetic.
module trace_traffic_gen_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [3:0]  ld_idx;
    logic [7:0]  ld_gap;
    logic [3:0]  ld_src;
    logic [3:0]  ld_dst;
    logic [1:0]  ld_op;
    logic [5:0]  ld_size;
    logic [15:0] ld_addr;
    logic [4:0]  cfg_len;
    logic        cfg_stat;
    logic [15:0] cfg_thresh;
    logic        start;
    logic        req_valid;
    logic        req_ready;
    logic [3:0]  req_src;
    logic [3:0]  req_dst;
    logic [1:0]  req_op;
    logic [5:0]  req_size;
    logic [15:0] req_addr;
    logic        done;
    logic [15:0] issued_cnt;
    logic [15:0] stall_cnt;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    trace_traffic_gen u_dut (
        .clk (clk), .rst_n (rst_n),
        .ld_en (ld_en), .ld_idx (ld_idx), .ld_gap (ld_gap), .ld_src (ld_src),
        .ld_dst (ld_dst), .ld_op (ld_op), .ld_size (ld_size), .ld_addr (ld_addr),
        .cfg_len (cfg_len), .cfg_stat (cfg_stat), .cfg_thresh (cfg_thresh),
        .start (start), .req_valid (req_valid), .req_ready (req_ready),
        .req_src (req_src), .req_dst (req_dst), .req_op (req_op),
        .req_size (req_size), .req_addr (req_addr), .done (done),
        .issued_cnt (issued_cnt), .stall_cnt (stall_cnt)
    );

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog R7: act=%0d cycles exp<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int e_gap(int k, int v);  return (k * 3 + v) % 8;  endfunction
    function automatic int e_src(int k, int v);  return (k + v) % 16;     endfunction
    function automatic int e_dst(int k);         return 15 - k;           endfunction
    function automatic int e_op(int k, int v);   return (k + v) % 4;      endfunction
    function automatic int e_size(int k, int v); return (k * 3 + v) % 64; endfunction
    function automatic int e_addr(int k, int v);
        return (e_op(k, v) < 2) ? (4096 + k * 17 + v) : 0;
    endfunction
    function automatic longint pack_exp(int k, int v);
        return (longint'(e_src(k, v)) << 32) | (longint'(e_dst(k)) << 28)
             | (longint'(e_op(k, v)) << 24) | (longint'(e_size(k, v)) << 16)
             | longint'(e_addr(k, v));
    endfunction
    function automatic longint pack_act();
        return (longint'(req_src) << 32) | (longint'(req_dst) << 28)
             | (longint'(req_op) << 24) | (longint'(req_size) << 16)
             | longint'(req_addr);
    endfunction

    function automatic bit ready_pat(int pat, int c);
        case (pat)
            0: return 1'b1;
            1: return (c % 3) != 2;
            default: return ((c * 7) % 5) < 2;
        endcase
    endfunction

    // R10: write all entries of variant v through the load port.
    task automatic load_all(input int v);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_idx  = 4'(k);
            ld_gap  = 8'(e_gap(k, v));
            ld_src  = 4'(e_src(k, v));
            ld_dst  = 4'(e_dst(k));
            ld_op   = 2'(e_op(k, v));
            ld_size = 6'(e_size(k, v));
            ld_addr = 16'(4096 + k * 17 + v);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic pulse_start(input bit rdy);
        @(negedge clk);
        start     = 1'b1;
        req_ready = rdy;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Observe one replay from the first post-start negedge to done.
    task automatic run_trace(input int len, input int v, input int pat, input bit stat);
        int  k = 0;
        int  low = 0;
        int  stalls = 0;
        int  c = 0;
        bit  fin = 0;
        while (!fin && c < 4000) begin
            req_ready = ready_pat(pat, c);
            if (req_valid) begin
                chk(pack_act() == pack_exp(k, v), "R4/R5/R6", "request fields",
                    pack_act(), pack_exp(k, v));
                if (req_ready) begin
                    if (!stat)
                        chk(low == e_gap(k, v), "R3/R6", "idle cycles before entry", low, e_gap(k, v));
                    else if (cfg_thresh == 16'hFFFF)
                        chk(low == 1, "R8", "stat gap at full threshold", low, 1);
                    else
                        chk(low >= 1, "R8", "stat gap at least one", low, 1);
                    k++;
                    low = 0;
                    if (k == len) fin = 1;
                end else begin
                    stalls++;
                end
            end else begin
                low++;
            end
            c++;
            @(negedge clk);
        end
        req_ready = 1'b0;
        chk(fin, "R7", "replay finished", k, len);
        chk(done && !req_valid, "R7", "done after last entry", {done, req_valid}, 2);
        chk(issued_cnt == 16'(len), "R9", "issued count", issued_cnt, len);
        chk(stall_cnt == 16'(stalls), "R9", "stall count", stall_cnt, stalls);
    endtask

    initial begin
        int seen;
        rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_gap = '0; ld_src = '0;
        ld_dst = '0; ld_op = '0; ld_size = '0; ld_addr = '0; cfg_len = '0;
        cfg_stat = 1'b0; cfg_thresh = '0; start = 1'b0; req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, and nothing offered without start.
        chk(!req_valid && !done, "R1", "valid/done after reset", {req_valid, done}, 0);
        chk(issued_cnt == 0 && stall_cnt == 0, "R1", "counters after reset", issued_cnt + stall_cnt, 0);
        repeat (5) @(negedge clk);
        chk(!req_valid, "R1", "idle without start", req_valid, 0);

        // Replay sweep: variants x ready patterns x lengths (R3..R7, R9, R10).
        for (int v = 0; v < 3; v++) begin
            load_all(v);
            for (int pat = 0; pat < 3; pat++) begin
                for (int li = 0; li < 3; li++) begin
                    int len = (li == 0) ? 1 : (li == 1) ? 5 : 16;
                    cfg_len = 5'(len);
                    pulse_start(1'b0);
                    run_trace(len, v, pat, 1'b0);
                end
            end
        end

        // R7: empty trace completes at once.
        cfg_len = 5'd0;
        pulse_start(1'b0);
        chk(done && !req_valid, "R7", "zero length done", {done, req_valid}, 2);

        // R2: restart collides with an accepted request.
        load_all(1);
        cfg_len = 5'd16;
        pulse_start(1'b0);
        for (int i = 0; i < 200; i++) begin
            req_ready = 1'b1;
            if (issued_cnt == 16'd3 && req_valid) break;
            @(negedge clk);
        end
        chk(req_valid && issued_cnt == 16'd3, "R2", "reached entry 3", issued_cnt, 3);
        start = 1'b1;
        req_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(issued_cnt == 0 && stall_cnt == 0, "R2", "counters cleared by restart", issued_cnt, 0);
        chk(!req_valid && !done, "R2", "entry 0 gap restarted", {req_valid, done}, 0);
        run_trace(16, 1, 0, 1'b0);

        // R8: statistical mode at full threshold, then a mid threshold.
        load_all(0);
        cfg_stat = 1'b1;
        cfg_thresh = 16'hFFFF;
        pulse_start(1'b0);
        run_trace(16, 0, 1, 1'b1);
        cfg_thresh = 16'h8000;
        pulse_start(1'b0);
        run_trace(16, 0, 2, 1'b1);

        // R8: zero threshold never issues.
        cfg_thresh = 16'h0000;
        pulse_start(1'b1);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            if (req_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0 && issued_cnt == 0, "R8", "zero threshold silent", seen, 0);
        cfg_stat = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule